// File: doc/BRIEF.md
# Peripheral Register Bit-Field Writer

This block carries out one coprocessor instruction: it places an 8-bit immediate into a chosen bit range of a 32-bit peripheral register and leaves the rest of that register alone. A caller presents a 32-bit instruction word together with a one-cycle start strobe. The block checks the opcode and splits out the range bounds, the immediate and the word address. It then runs a read-modify-write on a simple synchronous register bus.

The bus has a word address, a read strobe, read data that the peripheral returns one cycle after the strobe, write data and a write strobe. Between the read and the write, the block builds a mask from the range bounds. Bits inside the range take the immediate, counted from its least significant bit. If the range is wider than eight bits, its bits above the eighth are written as zero. If it is narrower, the upper bits of the immediate are dropped. Bits outside the range keep the value that was read back.

An instruction whose upper bound lies below its lower bound never reaches the bus. It raises a one-cycle error flag instead. The block signals `busy_o` while an operation is in flight and ignores further strobes during that time. A one-cycle `done_o` pulse marks the end of each write.

Top module: `bitfield_writer`

## Requirements
- R1: After a synchronous reset, bus_rd_o, bus_we_o, busy_o, done_o and err_o are all low.
- R2: A start strobe is acted on only when instruction bits [31:28] equal 4'd1. With any other opcode the strobe produces no bus cycle, no busy, no done and no error, and the peripheral register keeps its value.
- R3: The fields sit at fixed positions: upper bound in bits [27:23], lower bound in bits [22:18], immediate in bits [17:10] and word address in bits [9:0]. bus_addr_o carries the word address unchanged, including the maximum 1023.
- R4: If start is accepted at clock edge 0, bus_rd_o is high for exactly the cycle after edge 0. bus_we_o is high for exactly the cycle after edge 2. done_o is high for exactly the cycle after edge 3. bus_rdata_i is taken in the cycle after edge 1.
- R5: The written word equals the read word with bits [High:Low] replaced by the low bits of the immediate, shifted up to bit Low. Every bit outside [High:Low] is unchanged.
- R6: When High-Low+1 is greater than 8, the range bits from Low+8 up to High are written as zero.
- R7: When High-Low+1 is less than 8, only the low High-Low+1 bits of the immediate are written.
- R8: When High is less than Low, no read or write strobe is issued, done_o stays low, and err_o is high for exactly the cycle after the accepting edge.
- R9: busy_o is high from the cycle after the accepting edge through the write cycle, and is low in the done cycle. A start strobe seen while busy_o is high is ignored. A start strobe in the done cycle is accepted.
- R10: Ranges at the extremes work correctly: a single bit (High equal to Low, including bit 31) and the full word [31:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle strobe that launches the instruction on instr_i |
| instr_i | input | 32 | Instruction word |
| bus_addr_o | output | 10 | Word address of the target register |
| bus_rd_o | output | 1 | Read strobe; data returns one cycle later |
| bus_rdata_i | input | 32 | Read data from the peripheral |
| bus_wdata_o | output | 32 | Merged word to write |
| bus_we_o | output | 1 | Write strobe |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse for an inverted bit range |

## Verification
Two events can fall in the same cycle: a new start strobe and the block's own write or completion cycle. The bench raises a second strobe in the write cycle and another in the done cycle, each aimed at a separate register. In the first case that register must stay untouched while the first write still lands correctly. In the second case both writes must land with the expected merged values, and the second operation's read strobe must follow in the next cycle.

// File: rtl/bfw_pkg.sv
package bfw_pkg;
  localparam int INSTR_W  = 32;
  localparam int OPC_LSB  = 28;
  localparam int OPC_W    = 4;
  localparam int HI_LSB   = 23;
  localparam int LO_LSB   = 18;
  localparam int IMM_LSB  = 10;
  localparam int ADR_LSB  = 0;
  localparam int FLD_W    = 5;
  localparam int IMM_W    = 8;
  localparam int ADR_W    = 10;
  localparam logic [OPC_W-1:0] OPC_FIELD_WR = 4'd1;

  typedef struct packed {
    logic [FLD_W-1:0] hi;
    logic [FLD_W-1:0] lo;
    logic [IMM_W-1:0] imm;
    logic [ADR_W-1:0] addr;
  } bfw_op_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_WRITE = 2'd3
  } bfw_state_t;
endpackage

// File: rtl/bfw_decode.sv
module bfw_decode
  import bfw_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output bfw_op_t            op,
  output logic               is_fieldwr,
  output logic               range_ok
);
  always_comb begin
    op.hi      = instr[HI_LSB  +: FLD_W];
    op.lo      = instr[LO_LSB  +: FLD_W];
    op.imm     = instr[IMM_LSB +: IMM_W];
    op.addr    = instr[ADR_LSB +: ADR_W];
    is_fieldwr = (instr[OPC_LSB +: OPC_W] == OPC_FIELD_WR);
    range_ok   = (op.hi >= op.lo);
  end
endmodule

// File: rtl/bfw_merge.sv
module bfw_merge #(
  parameter int DATA_W = 32,
  parameter int FLD_W  = 5,
  parameter int IMM_W  = 8
) (
  input  logic [FLD_W-1:0]  hi,
  input  logic [FLD_W-1:0]  lo,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] old_word,
  output logic [DATA_W-1:0] new_word
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] fill;
  logic [DATA_W-1:0] sel;

  // Immediate placed at bit lo; its zero extension pads a wide range.
  assign fill = {{PAD_W{1'b0}}, imm} << lo;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic [FLD_W-1:0] IDX = FLD_W'(i);
    assign sel[i]      = (IDX >= lo) && (IDX <= hi);
    assign new_word[i] = sel[i] ? fill[i] : old_word[i];
  end
endmodule

// File: rtl/bfw_ctrl.sv
module bfw_ctrl
  import bfw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  bfw_op_t           op_in,
  input  logic              is_fieldwr,
  input  logic              range_ok,
  input  logic [DATA_W-1:0] merged,
  output bfw_op_t           op_q,
  output logic [ADR_W-1:0]  addr,
  output logic              rd,
  output logic              we,
  output logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic              err
);
  bfw_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      op_q  <= '0;
      addr  <= '0;
      rd    <= 1'b0;
      we    <= 1'b0;
      wdata <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      rd   <= 1'b0;
      we   <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start && is_fieldwr) begin
            if (range_ok) begin
              op_q  <= op_in;
              addr  <= op_in.addr;
              rd    <= 1'b1;
              busy  <= 1'b1;
              state <= ST_READ;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_READ: state <= ST_WAIT;
        ST_WAIT: begin
          wdata <= merged;
          we    <= 1'b1;
          state <= ST_WRITE;
        end
        default: begin
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assert_bus_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(rd && we));
  assert_write_after_read_R4: assert property (@(posedge clk) disable iff (rst)
    we |-> $past(rd, 2));
  assert_done_after_write_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(we));
  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && !rd && !we && !done));
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(addr));
  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/bitfield_writer.sv
module bitfield_writer
  import bfw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [31:0]       instr_i,
  output logic [9:0]        bus_addr_o,
  output logic              bus_rd_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_we_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  bfw_op_t           dec_op;
  bfw_op_t           cur_op;
  logic              dec_fieldwr;
  logic              dec_range_ok;
  logic [DATA_W-1:0] merged;

  bfw_decode u_decode (
    .instr      (instr_i),
    .op         (dec_op),
    .is_fieldwr (dec_fieldwr),
    .range_ok   (dec_range_ok)
  );

  bfw_merge #(.DATA_W(DATA_W), .FLD_W(FLD_W), .IMM_W(IMM_W)) u_merge (
    .hi       (cur_op.hi),
    .lo       (cur_op.lo),
    .imm      (cur_op.imm),
    .old_word (bus_rdata_i),
    .new_word (merged)
  );

  bfw_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start_i),
    .op_in      (dec_op),
    .is_fieldwr (dec_fieldwr),
    .range_ok   (dec_range_ok),
    .merged     (merged),
    .op_q       (cur_op),
    .addr       (bus_addr_o),
    .rd         (bus_rd_o),
    .we         (bus_we_o),
    .wdata      (bus_wdata_o),
    .busy       (busy_o),
    .done       (done_o),
    .err        (err_o)
  );
endmodule

// File: tb/test_bitfield_writer.sv
module test_bitfield_writer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [9:0]  bus_addr_o;
  logic        bus_rd_o;
  logic [31:0] bus_rdata_i;
  logic [31:0] bus_wdata_o;
  logic        bus_we_o;
  logic        busy_o, done_o, err_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] regs [1024];
  logic [7:0] rd_m, we_m, done_m, busy_m, err_m;

  always #5 clk = ~clk;

  bitfield_writer i_bitfield_writer (
    .clk(clk), .rst(rst), .start_i(start_i), .instr_i(instr_i),
    .bus_addr_o(bus_addr_o), .bus_rd_o(bus_rd_o), .bus_rdata_i(bus_rdata_i),
    .bus_wdata_o(bus_wdata_o), .bus_we_o(bus_we_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  // Register model: read data valid one cycle after the read strobe.
  always @(posedge clk) begin
    if (bus_rd_o) bus_rdata_i <= regs[bus_addr_o];
    if (bus_we_o) regs[bus_addr_o] <= bus_wdata_o;
  end

  function automatic logic [31:0] mk(input logic [3:0] opc, input int hi,
      input int lo, input logic [7:0] d, input logic [9:0] a);
    logic [31:0] w;
    w = '0;
    w[31:28] = opc;
    w[27:23] = 5'(hi);
    w[22:18] = 5'(lo);
    w[17:10] = d;
    w[9:0]   = a;
    return w;
  endfunction

  function automatic logic [31:0] expect_word(input logic [31:0] old,
      input int hi, input int lo, input logic [7:0] d);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (i >= lo && i <= hi) r[i] = (i - lo < 8) ? d[i - lo] : 1'b0;
      else r[i] = old[i];
    end
    return r;
  endfunction

  task automatic check(input string req, input string what,
      input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Launches ins, records outputs at negedges 1..7; a second strobe with
  // ins2 is driven for one cycle starting at negedge k2 (0 = none).
  task automatic run(input logic [31:0] ins, input int k2, input logic [31:0] ins2);
    rd_m = '0; we_m = '0; done_m = '0; busy_m = '0; err_m = '0;
    @(negedge clk);
    start_i = 1'b1; instr_i = ins;
    for (int k = 1; k < 8; k++) begin
      @(negedge clk);
      rd_m[k] = bus_rd_o; we_m[k] = bus_we_o; done_m[k] = done_o;
      busy_m[k] = busy_o; err_m[k] = err_o;
      start_i = (k == k2);
      instr_i = (k == k2) ? ins2 : ins;
    end
    start_i = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1", "outputs after reset",
          {27'd0, bus_rd_o, bus_we_o, busy_o, done_o, err_o}, 32'd0);
  endtask

  task automatic t_basic;
    regs[5] = 32'h1234_5678;
    run(mk(4'd1, 11, 4, 8'hA5, 10'd5), 0, '0);
    check("R4", "read strobe timing",  {24'd0, rd_m},   32'h02);
    check("R4", "write strobe timing", {24'd0, we_m},   32'h08);
    check("R4", "done timing",         {24'd0, done_m}, 32'h10);
    check("R9", "busy window",         {24'd0, busy_m}, 32'h0E);
    check("R5", "merged word", regs[5], expect_word(32'h1234_5678, 11, 4, 8'hA5));
  endtask

  task automatic t_maxaddr;
    regs[1023] = 32'hF0F0_F0F0;
    regs[0]    = 32'h0;
    run(mk(4'd1, 7, 0, 8'h3C, 10'd1023), 0, '0);
    check("R3", "top address written", regs[1023], 32'hF0F0_F03C);
    check("R3", "address 0 untouched", regs[0], 32'h0);
  endtask

  task automatic t_wide;
    regs[7] = 32'hDEAD_BEEF;
    run(mk(4'd1, 31, 0, 8'h3C, 10'd7), 0, '0);
    check("R6", "full-width zero fill", regs[7], 32'h0000_003C);
    regs[8] = 32'hFFFF_FFFF;
    run(mk(4'd1, 25, 6, 8'h81, 10'd8), 0, '0);
    check("R6", "wide range zero fill", regs[8], expect_word(32'hFFFF_FFFF, 25, 6, 8'h81));
  endtask

  task automatic t_narrow;
    regs[9] = 32'h0;
    run(mk(4'd1, 18, 16, 8'hFF, 10'd9), 0, '0);
    check("R7", "3-bit range", regs[9], 32'h0007_0000);
    regs[10] = 32'hFFFF_FFFF;
    run(mk(4'd1, 13, 10, 8'hF2, 10'd10), 0, '0);
    check("R7", "4-bit truncation", regs[10], 32'hFFFF_CBFF);
  endtask

  task automatic t_single;
    regs[11] = 32'h0000_0001;
    run(mk(4'd1, 31, 31, 8'h01, 10'd11), 0, '0);
    check("R10", "bit 31 set", regs[11], 32'h8000_0001);
    regs[12] = 32'hFFFF_FFFF;
    run(mk(4'd1, 0, 0, 8'hFE, 10'd12), 0, '0);
    check("R10", "bit 0 cleared", regs[12], 32'hFFFF_FFFE);
  endtask

  task automatic t_badrange;
    regs[13] = 32'hCAFE_F00D;
    run(mk(4'd1, 3, 9, 8'h55, 10'd13), 0, '0);
    check("R8", "err pulse", {24'd0, err_m}, 32'h02);
    check("R8", "no bus or done", {8'd0, rd_m, we_m, done_m}, 32'd0);
    check("R8", "register kept", regs[13], 32'hCAFE_F00D);
  endtask

  task automatic t_opcode;
    regs[14] = 32'h0BAD_0BAD;
    run(mk(4'd2, 15, 0, 8'h00, 10'd14), 0, '0);
    check("R2", "foreign opcode quiet",
          {rd_m, we_m, busy_m, done_m | err_m}, 32'd0);
    check("R2", "register kept", regs[14], 32'h0BAD_0BAD);
  endtask

  task automatic t_busy_ignore;
    regs[20] = 32'h0; regs[21] = 32'h1111_1111; regs[22] = 32'h2222_2222;
    run(mk(4'd1, 7, 0, 8'h99, 10'd20), 2, mk(4'd1, 7, 0, 8'h00, 10'd21));
    check("R9", "strobe in wait cycle ignored", regs[21], 32'h1111_1111);
    run(mk(4'd1, 7, 0, 8'h77, 10'd20), 3, mk(4'd1, 7, 0, 8'h00, 10'd22));
    check("R9", "strobe in write cycle ignored", regs[22], 32'h2222_2222);
    check("R9", "first op intact", regs[20], 32'h0000_0077);
  endtask

  task automatic t_back2back;
    regs[30] = 32'h0; regs[31] = 32'hFFFF_FFFF;
    run(mk(4'd1, 15, 8, 8'h12, 10'd30), 4, mk(4'd1, 23, 16, 8'h34, 10'd31));
    check("R9", "second read right after done", {24'd0, rd_m}, 32'h22);
    check("R9", "first op", regs[30], 32'h0000_1200);
    check("R9", "op accepted in done cycle", regs[31], 32'hFF34_FFFF);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) regs[i] = 32'(i) * 32'h0101_0101;
    bus_rdata_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_maxaddr();
    t_wide();
    t_narrow();
    t_single();
    t_badrange();
    t_opcode();
    t_busy_ignore();
    t_back2back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule